// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA channel for PIO and multiword DMA cycles. Each request names a direction, whether it is a data transfer or a task-file register access, whether it opens a burst, and which of the two attached devices it targets. The block looks up that device's packed 32-bit timing word and runs one strobe cycle. The cycle has an optional first-cycle setup delay, then an active low phase, then an inactive high phase, then a one-cycle done pulse.

Data transfers and task-file accesses take separate active times, inactive times and setup delays from the same word. The timing word is captured when a request is accepted. A configuration write that arrives while a cycle runs therefore changes only later cycles. When the word's Ultra DMA enable bit is set, the request is refused with an error pulse and no strobe is driven.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset, and whenever no cycle is running, `rd_stb_n` and `wr_stb_n` are 1, `done` and `err` are 0, and `req_ready` is 1. Both timing words reset to 0.
- R2: For a data transfer, the strobe is low for word[7:4]+1 cycles and then high for word[3:0]+1 cycles.
- R3: For a task-file access, the strobe is low for word[15:12]+1 cycles and then high for word[11:8]+1 cycles.
- R4: When `req_first` is 1, the low phase is preceded by word[21:19] idle cycles for a data transfer, or word[24:22] idle cycles for a task-file access. When `req_first` is 0, there is no setup delay.
- R5: A read (`req_write`=0) drives only `rd_stb_n` low. A write (`req_write`=1) drives only `wr_stb_n` low. The two strobes are never low together.
- R6: `done` is 1 for exactly the one cycle after the high phase. `req_ready` is 0 from the cycle after acceptance through that done cycle, and is 1 in the following cycle.
- R7: A request is accepted only at a clock edge where `req_ready` is 1. A `req_valid` that is high while busy is ignored and is not queued.
- R8: When word bit 28 is 1, the request is refused. `err` is 1 for one cycle after acceptance, no strobe is driven, `done` stays 0, and `req_ready` returns the cycle after.
- R9: A cycle uses the timing word as it stood at the acceptance edge. A `cfg_we` at that same edge, or during the cycle, affects only later requests.
- R10: Each device has its own timing word. `cfg_dev` selects which word a write updates, and `req_dev` selects which word a request uses. Bits 29 and 31 do not affect timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data transfer |
| req_first | input | 1 | 1 = first cycle of a burst (apply setup delay) |
| req_dev | input | 1 | Device whose timing word is used |
| req_ready | output | 1 | Idle, able to accept a request |
| cfg_we | input | 1 | Timing word write enable |
| cfg_dev | input | 1 | Device whose timing word is written |
| cfg_wdata | input | 32 | New timing word |
| rd_stb_n | output | 1 | Active-low read strobe |
| wr_stb_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle pulse at the end of a strobe cycle |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
The assertions assume that reset is applied before any request, and that request fields are stable in the cycle where `req_valid` is sampled. No other handshake is assumed. The properties hold for any timing word, including all-ones fields and a set Ultra DMA bit. The bench changes inputs only on the falling clock edge. It deliberately holds `req_valid` high during busy cycles and issues configuration writes both mid-cycle and on the acceptance edge, so the ignore and latch-at-start rules are exercised.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
  localparam int CFG_W   = 32;
  localparam int TIME_W  = 4;
  localparam int SETUP_W = 3;

  localparam int DAT_INACT_LSB = 0;
  localparam int DAT_ACT_LSB   = 4;
  localparam int TF_INACT_LSB  = 8;
  localparam int TF_ACT_LSB    = 12;
  localparam int DAT_SETUP_LSB = 19;
  localparam int TF_SETUP_LSB  = 22;
  localparam int UDMA_BIT      = 28;

  typedef struct packed {
    logic               udma;
    logic [SETUP_W-1:0] setup;
    logic [TIME_W-1:0]  act;
    logic [TIME_W-1:0]  inact;
  } strobe_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACT, ST_INACT, ST_DONE, ST_REJ
  } seq_state_t;

  // Extracts the fields for one request kind from a packed timing word.
  function automatic strobe_timing_t pick_timing(input logic [CFG_W-1:0] w,
                                                 input logic taskfile,
                                                 input logic first);
    strobe_timing_t t;
    t.udma = w[UDMA_BIT];
    if (taskfile) begin
      t.act   = w[TF_ACT_LSB   +: TIME_W];
      t.inact = w[TF_INACT_LSB +: TIME_W];
      t.setup = first ? w[TF_SETUP_LSB +: SETUP_W] : '0;
    end else begin
      t.act   = w[DAT_ACT_LSB   +: TIME_W];
      t.inact = w[DAT_INACT_LSB +: TIME_W];
      t.setup = first ? w[DAT_SETUP_LSB +: SETUP_W] : '0;
    end
    return t;
  endfunction
endpackage

// File: rtl/ata_cfg_bank.sv
module ata_cfg_bank
  import ata_strobe_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DEV_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DEV_W-1:0] wr_dev,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [DEV_W-1:0] rd_dev,
  output logic [CFG_W-1:0] rd_word
);
  logic [CFG_W-1:0] words [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr_en && (wr_dev == DEV_W'(g)))
        words[g] <= wr_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (rd_dev == DEV_W'(i)) rd_word = words[i];
  end
endmodule

// File: rtl/ata_timing_sel.sv
module ata_timing_sel
  import ata_strobe_pkg::*;
(
  input  logic [CFG_W-1:0] word,
  input  logic             taskfile,
  input  logic             first,
  output strobe_timing_t   tim
);
  assign tim = pick_timing(word, taskfile, first);
endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
  import ata_strobe_pkg::*;
#(
  parameter int CNT_W = TIME_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  strobe_timing_t tim,
  output logic           accept,
  output logic           ready,
  output logic           rd_stb_n,
  output logic           wr_stb_n,
  output logic           done,
  output logic           err
);
  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [TIME_W-1:0] lat_act, lat_inact;
  logic              lat_write;
  logic              cnt_zero;

  assign ready    = (state == ST_IDLE);
  assign accept   = ready && req_valid;
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      lat_act   <= '0;
      lat_inact <= '0;
      lat_write <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          lat_act   <= tim.act;
          lat_inact <= tim.inact;
          lat_write <= req_write;
          if (tim.udma)
            state <= ST_REJ;
          else if (tim.setup != '0) begin
            state <= ST_SETUP;
            cnt   <= CNT_W'(tim.setup) - CNT_W'(1);
          end else begin
            state <= ST_ACT;
            cnt   <= CNT_W'(tim.act);
          end
        end
        ST_SETUP: if (cnt_zero) begin
          state <= ST_ACT;
          cnt   <= CNT_W'(lat_act);
        end else cnt <= cnt - CNT_W'(1);
        ST_ACT: if (cnt_zero) begin
          state <= ST_INACT;
          cnt   <= CNT_W'(lat_inact);
        end else cnt <= cnt - CNT_W'(1);
        ST_INACT: if (cnt_zero) state <= ST_DONE;
                  else cnt <= cnt - CNT_W'(1);
        ST_DONE: state <= ST_IDLE;
        ST_REJ:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_stb_n = !((state == ST_ACT) && !lat_write);
  assign wr_stb_n = !((state == ST_ACT) &&  lat_write);
  assign done     = (state == ST_DONE);
  assign err      = (state == ST_REJ);
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_taskfile,
  input  logic             req_first,
  input  logic [DEV_W-1:0] req_dev,
  output logic             req_ready,
  input  logic             cfg_we,
  input  logic [DEV_W-1:0] cfg_dev,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             rd_stb_n,
  output logic             wr_stb_n,
  output logic             done,
  output logic             err
);
  logic [CFG_W-1:0] sel_word;
  strobe_timing_t   sel_tim;
  logic             cycle_start;

  ata_cfg_bank #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_dev  (cfg_dev),
    .wr_data (cfg_wdata),
    .rd_dev  (req_dev),
    .rd_word (sel_word)
  );

  ata_timing_sel i_sel (
    .word     (sel_word),
    .taskfile (req_taskfile),
    .first    (req_first),
    .tim      (sel_tim)
  );

  ata_strobe_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tim       (sel_tim),
    .accept    (cycle_start),
    .ready     (req_ready),
    .rd_stb_n  (rd_stb_n),
    .wr_stb_n  (wr_stb_n),
    .done      (done),
    .err       (err)
  );
endmodule

// File: rtl/ata_strobe_gen_sva.sv
module ata_strobe_gen_sva (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_stb_n,
  input logic wr_stb_n,
  input logic done,
  input logic err,
  input logic cycle_start
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_stb_n && wr_stb_n && !done && !err)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_stb_n && !wr_stb_n)); // R5
  AST_DONE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_stb_n && wr_stb_n && !req_ready)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> req_ready); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !req_ready); // R7
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rd_stb_n && wr_stb_n && !done)); // R8
endmodule

bind ata_strobe_gen ata_strobe_gen_sva i_sva (.*);

// File: tb/test_ata_strobe_gen.sv
`timescale 1ns/1ps
module test_ata_strobe_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_taskfile = 0, req_first = 0;
  logic req_dev = 0, cfg_we = 0, cfg_dev = 0;
  logic [31:0] cfg_wdata = '0;
  logic req_ready, rd_stb_n, wr_stb_n, done, err;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ata_strobe_gen i_ata_strobe_gen (.*);

  typedef struct {
    logic [4:0] v;   // {ready, rd_n, wr_n, done, err}
    string      tag;
  } exp_t;

  exp_t       q[$];
  logic [31:0] mcfg [2];

  function automatic void push(logic [4:0] v, string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    q.push_back(e);
  endfunction

  // Behavioural reference: builds the expected output stream for one request.
  function automatic void plan_cycle(logic [31:0] w, bit wr, bit tf, bit first, bit dev);
    int s, a, h;
    string dtag;
    dtag = dev ? " R10" : "";
    if (w[28]) begin
      push(5'b01101, {"R8", dtag});
      return;
    end
    s = !first ? 0 : (tf ? int'((w >> 22) & 7) : int'((w >> 19) & 7));
    a = tf ? int'((w >> 12) & 15) : int'((w >> 4) & 15);
    h = tf ? int'((w >> 8) & 15) : int'(w & 15);
    for (int i = 0; i < s; i++) push(5'b01100, {"R4", dtag});
    for (int i = 0; i <= a; i++)
      push(wr ? 5'b01000 : 5'b00100, {tf ? "R3 R5" : "R2 R5", dtag});
    for (int i = 0; i <= h; i++) push(5'b01100, {tf ? "R3" : "R2", dtag});
    push(5'b01110, {"R6", dtag});
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      mcfg[0] = '0; mcfg[1] = '0;
    end else begin
      bit acc;
      acc = req_valid && (q.size() == 0);
      if (q.size() != 0) void'(q.pop_front());
      if (acc) plan_cycle(mcfg[req_dev], req_write, req_taskfile, req_first, req_dev);
      if (cfg_we) mcfg[cfg_dev] = cfg_wdata;  // R9: applied after acceptance
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [4:0] act, expv;
      string tag;
      act = {req_ready, rd_stb_n, wr_stb_n, done, err};
      if (q.size() == 0) begin expv = 5'b11100; tag = "R1 R7"; end
      else begin expv = q[0].v; tag = q[0].tag; end
      checks++;
      if (act !== expv) begin
        failures++;
        $display("FAIL %s: got %b expected %b at %0t", tag, act, expv, $time);
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] a, logic [31:0] e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, a, e);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic request(bit wr, bit tf, bit first, bit dev);
    wait_idle();
    req_valid = 1; req_write = wr; req_taskfile = tf; req_first = first; req_dev = dev;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic write_cfg(bit dev, logic [31:0] w);
    cfg_we = 1; cfg_dev = dev; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [31:0] mk(int tsu, int dsu, int ta, int ti, int da, int di);
    return 32'((tsu << 22) | (dsu << 19) | (ta << 12) | (ti << 8) | (da << 4) | di);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during and right after reset
    chk(rd_stb_n && wr_stb_n && !done && !err, "R1", {rd_stb_n, wr_stb_n, done, err}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", req_ready, 1);
    // R2 R3: zero timing words give one-cycle phases
    request(0, 0, 1, 0);
    // R10: bits 29 and 31 set; they must not alter timing
    wait_idle();
    write_cfg(0, mk(3, 2, 5, 4, 3, 2) | 32'hA000_0000);
    write_cfg(1, mk(7, 1, 1, 1, 0, 0));
    request(0, 0, 0, 0);   // R2 read data
    request(1, 0, 1, 0);   // R4 R5 write data first
    request(0, 1, 1, 0);   // R3 R4 read taskfile first
    request(1, 1, 0, 0);   // R3 write taskfile
    request(0, 0, 1, 1);   // R10 device 1
    request(1, 1, 1, 1);   // R4 max task-file setup
    // R7: hold valid during the busy cycle; nothing may be queued
    request(1, 0, 0, 0);
    req_valid = 1; req_write = 0; req_taskfile = 1;
    repeat (4) @(negedge clk);
    req_valid = 0;
    wait_idle();
    chk(!done && rd_stb_n, "R7", {done, rd_stb_n}, 2'b01);
    // R9: mid-cycle write to the running device only affects the next cycle
    request(0, 0, 0, 0);
    write_cfg(0, mk(1, 1, 2, 2, 9, 6));
    request(0, 0, 0, 0);
    // R9: write on the acceptance edge itself
    wait_idle();
    req_valid = 1; req_write = 1; req_taskfile = 0; req_first = 1; req_dev = 0;
    cfg_we = 1; cfg_dev = 0; cfg_wdata = mk(0, 4, 0, 0, 1, 1);
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    request(1, 0, 1, 0);
    // R8: Ultra DMA bit refuses the request
    wait_idle();
    write_cfg(1, 32'h1000_0000 | mk(2, 2, 2, 2, 2, 2));
    request(1, 0, 1, 1);
    @(negedge clk);
    chk(err === 1'b0 && wr_stb_n === 1'b1, "R8", {err, wr_stb_n}, 2'b01);
    request(0, 0, 0, 0);   // R10: device 0 unaffected by device 1 word
    // R2 R4: largest field values
    wait_idle();
    write_cfg(0, mk(7, 7, 15, 15, 15, 15));
    request(0, 0, 1, 0);
    request(1, 1, 1, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule